// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address (a segment number and an offset within that segment) into a flat physical address. The segment descriptors sit in ordinary memory. A table-origin register and a segment-count register, both loaded through a small configuration port, say where the table starts and how many of its entries are in use. Each request also carries an access kind: read, write or execute.

For each request the unit first compares the segment number with the segment count. If that check passes, it reads the descriptor's attribute word through a memory read port. That word holds the valid flag, the read, write and execute permissions and the segment length. Only when every check passes does it read the base word and return base plus offset. Any failed check ends the translation at once with a trap code that names the first failing check. Requests and responses use valid/ready handshakes, and only one translation is in progress at a time.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are both 0.
- R2: A cycle with `cfg_we`=1 loads `cfg_wdata` into the table origin when `cfg_sel`=0, or bits [SEG_W:0] of `cfg_wdata` into the segment count when `cfg_sel`=1. Later descriptor reads and count checks use the new value.
- R3: A segment number greater than or equal to the segment count ends with trap code 1 and issues no memory read.
- R4: A descriptor is 8 bytes at origin + segment×8. The attribute word at byte offset 4 is read first. The base word at offset 0 is read second, and only if every check passes. A memory request holds its address until `mem_req_ready` accepts it.
- R5: Attribute bit 31 is the valid flag. When it is 0, the result is trap code 2 and the base word is not read.
- R6: Access codes are 0 = read, 1 = write and 2 = execute. They need attribute bits 30, 29 and 28 respectively. Code 3 is never permitted. A missing permission gives trap code 3.
- R7: Attribute bits [23:0] give the segment length. An offset greater than or equal to it gives trap code 4.
- R8: When several checks would fail, the trap code reports the first in this order: count (1), valid (2), permission (3), length (4). Codes above 4 never appear.
- R9: When all checks pass, the response has trap code 0 and `rsp_paddr` = base word + offset, modulo 2^32.
- R10: `req_ready` is 1 only while no translation is in progress. It stays 0 from request acceptance until the response is taken. A response holds its values while `rsp_ready` is 0.
- R11: A response with a nonzero trap code has `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table origin, 1 selects segment count |
| cfg_wdata | input | ADDR_W | Configuration write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Byte address of descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_paddr | output | ADDR_W | Physical address, 0 on trap |
| rsp_trap | output | 3 | 0 ok, 1 count, 2 invalid, 3 permission, 4 length |

## Verification
The bench builds the unit with SEG_W=4 and OFF_W=20 and sets a segment count of 4, then 5, then 0. Segment numbers from 4 up to 15 are therefore legal inputs above the count, and the count check can be tried against both small and empty tables. A table of hand-built descriptors covers exact length boundaries and several permission masks. It also includes an invalid entry with no permissions whose length is exceeded, to exercise the trap priority order. A base near the top of the address space checks that the final addition wraps. Moving the table origin during the run shows that descriptor addresses follow the origin register.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ATTR_REQ = 3'd1,
        ST_ATTR_WT  = 3'd2,
        ST_BASE_REQ = 3'd3,
        ST_BASE_WT  = 3'd4,
        ST_RESP     = 3'd5
    } xl_state_e;

    typedef enum logic [2:0] {
        TRAP_NONE    = 3'd0,
        TRAP_SEGNUM  = 3'd1,
        TRAP_INVALID = 3'd2,
        TRAP_PERM    = 3'd3,
        TRAP_LENGTH  = 3'd4
    } trap_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned DESC_BYTES  = 8;
    localparam int unsigned ATTR_BYTE   = 4;
    localparam int unsigned LEN_W       = 24;
    localparam int unsigned BIT_VALID   = 31;
    localparam int unsigned BIT_RD      = 30;
    localparam int unsigned BIT_WR      = 29;
    localparam int unsigned BIT_EX      = 28;

endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] tbl_origin_q,
    output logic [SEG_W:0]    tbl_count_q
);

    logic [ADDR_W-1:0] tbl_origin_d;
    logic [SEG_W:0]    tbl_count_d;

    always_comb begin
        tbl_origin_d = tbl_origin_q;
        tbl_count_d  = tbl_count_q;
        if (cfg_we) begin
            if (cfg_sel) tbl_count_d  = cfg_wdata[SEG_W:0];
            else         tbl_origin_d = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_origin_q <= '0;
            tbl_count_q  <= '0;
        end else begin
            tbl_origin_q <= tbl_origin_d;
            tbl_count_q  <= tbl_count_d;
        end
    end

endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_xlate_pkg::*;
#(
    parameter int unsigned OFF_W = 24
) (
    input  logic [WORD_W-1:0] attr_word,
    input  logic [1:0]        acc,
    input  logic [OFF_W-1:0]  off,
    output trap_e             trap
);

    localparam int unsigned CMP_W = (OFF_W > LEN_W) ? OFF_W : LEN_W;

    logic            perm_ok;
    logic [CMP_W-1:0] off_ext;
    logic [CMP_W-1:0] len_ext;
    logic            unused_attr_bits;

    assign unused_attr_bits = ^attr_word[BIT_EX-1:LEN_W];
    assign off_ext = CMP_W'(off);
    assign len_ext = CMP_W'(attr_word[LEN_W-1:0]);

    always_comb begin
        case (acc)
            ACC_READ:  perm_ok = attr_word[BIT_RD];
            ACC_WRITE: perm_ok = attr_word[BIT_WR];
            ACC_EXEC:  perm_ok = attr_word[BIT_EX];
            default:   perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (!attr_word[BIT_VALID])  trap = TRAP_INVALID;
        else if (!perm_ok)          trap = TRAP_PERM;
        else if (off_ext >= len_ext) trap = TRAP_LENGTH;
        else                        trap = TRAP_NONE;
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SEG_W  = 8,
    parameter int unsigned OFF_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_trap
);

    localparam int unsigned DESC_SHIFT = $clog2(DESC_BYTES);

    typedef struct packed {
        xl_state_e         st;
        logic [SEG_W-1:0]  seg;
        logic [OFF_W-1:0]  off;
        logic [1:0]        acc;
        logic [ADDR_W-1:0] paddr;
        trap_e             trap;
    } ctx_t;

    ctx_t              ctx_d, ctx_q;
    logic [ADDR_W-1:0] tbl_origin;
    logic [SEG_W:0]    tbl_count;
    trap_e             desc_trap;
    logic [ADDR_W-1:0] desc_addr;

    seg_tbl_regs #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .tbl_origin_q (tbl_origin),
        .tbl_count_q  (tbl_count)
    );

    seg_desc_check #(.OFF_W(OFF_W)) u_check (
        .attr_word (mem_rsp_data),
        .acc       (ctx_q.acc),
        .off       (ctx_q.off),
        .trap      (desc_trap)
    );

    assign desc_addr = tbl_origin + (ADDR_W'(ctx_q.seg) << DESC_SHIFT);

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.seg   = req_seg;
                    ctx_d.off   = req_off;
                    ctx_d.acc   = req_acc;
                    ctx_d.paddr = '0;
                    if ({1'b0, req_seg} >= tbl_count) begin
                        ctx_d.trap = TRAP_SEGNUM;
                        ctx_d.st   = ST_RESP;
                    end else begin
                        ctx_d.trap = TRAP_NONE;
                        ctx_d.st   = ST_ATTR_REQ;
                    end
                end
            end
            ST_ATTR_REQ: if (mem_req_ready) ctx_d.st = ST_ATTR_WT;
            ST_ATTR_WT: begin
                if (mem_rsp_valid) begin
                    if (desc_trap != TRAP_NONE) begin
                        ctx_d.trap = desc_trap;
                        ctx_d.st   = ST_RESP;
                    end else begin
                        ctx_d.st   = ST_BASE_REQ;
                    end
                end
            end
            ST_BASE_REQ: if (mem_req_ready) ctx_d.st = ST_BASE_WT;
            ST_BASE_WT: begin
                if (mem_rsp_valid) begin
                    ctx_d.paddr = ADDR_W'(mem_rsp_data) + ADDR_W'(ctx_q.off);
                    ctx_d.st    = ST_RESP;
                end
            end
            ST_RESP: if (rsp_ready) ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign req_ready     = (ctx_q.st == ST_IDLE);
    assign mem_req_valid = (ctx_q.st == ST_ATTR_REQ) || (ctx_q.st == ST_BASE_REQ);
    assign mem_req_addr  = (ctx_q.st == ST_ATTR_REQ) ? desc_addr + ADDR_W'(ATTR_BYTE)
                                                     : desc_addr;
    assign rsp_valid     = (ctx_q.st == ST_RESP);
    assign rsp_paddr     = ctx_q.paddr;
    assign rsp_trap      = ctx_q.trap;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SEG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEG_W-1:0]  req_seg,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [2:0]        rsp_trap,
    input logic [SEG_W:0]    tbl_count
);

    logic       oob_q;
    logic [1:0] reads_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oob_q   <= 1'b0;
            reads_q <= '0;
        end else if (req_valid && req_ready) begin
            oob_q   <= ({1'b0, req_seg} >= tbl_count);
            reads_q <= '0;
        end else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) begin
            reads_q <= reads_q + 2'd1;
        end
    end

    assert_no_read_on_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oob_q |-> !mem_req_valid);
    assert_count_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oob_q && rsp_valid) |-> rsp_trap == 3'd1);
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    assert_read_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reads_q <= 2'd2);
    assert_no_base_on_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap >= 3'd2) |-> reads_q == 2'd1);
    assert_trap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_trap <= 3'd4);
    assert_ok_two_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap == 3'd0) |-> reads_q == 2'd2);
    assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready);
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_trap)));
    assert_trap_zero_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap != 3'd0) |-> rsp_paddr == '0);

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_seg       (req_seg),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_trap      (rsp_trap),
    .tbl_count     (tbl_count)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

    localparam int ADDR_W = 32;
    localparam int SEG_W  = 4;
    localparam int OFF_W  = 20;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              cfg_we = 0, cfg_sel = 0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              req_valid = 0, req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              mem_req_valid, mem_req_ready = 1;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 0;
    logic [31:0]       mem_rsp_data = '0;
    logic              rsp_valid, rsp_ready = 0;
    logic [ADDR_W-1:0] rsp_paddr;
    logic [2:0]        rsp_trap;

    int checks = 0, failures = 0;
    bit busy = 0, started = 0;
    logic [31:0] tb_origin = 0;
    int          tb_count = 0;
    logic [31:0] d_base [16];
    logic [31:0] d_attr [16];
    logic [31:0] rd_q [$];

    always #10 clk = ~clk;

    seg_xlate #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] idx;
        if (a >= tb_origin && a < tb_origin + 32'd128) begin
            idx = (a - tb_origin) >> 3;
            return a[2] ? d_attr[idx[3:0]] : d_base[idx[3:0]];
        end
        return 32'hDEAD_BEEF;
    endfunction

    // memory responder: one cycle after acceptance, data returned
    initial forever begin
        @(negedge clk);
        mem_rsp_valid = 0;
        if (mem_req_valid && mem_req_ready) begin
            rd_q.push_back(mem_req_addr);
            @(negedge clk);
            mem_rsp_data  = mem_word(rd_q[$]);
            mem_rsp_valid = 1;
        end
    end

    // per-clock comparison of acceptance readiness against the model (R10)
    always @(negedge clk) if (started) chk(req_ready == !busy, "R10 req_ready", 32'(req_ready), 32'(!busy));

    task automatic cfg(input bit sel, input logic [31:0] v);
        @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk); cfg_we = 0;
        if (sel) tb_count = int'(v[SEG_W:0]); else tb_origin = v;
    endtask

    task automatic xlate(input int seg, input logic [OFF_W-1:0] off, input logic [1:0] acc,
                         input int hold, input string tag);
        int          etrap;
        logic [31:0] epa, w1, dadr;
        bit          perm;
        etrap = 0; epa = 0; w1 = d_attr[seg];
        dadr = tb_origin + 32'(seg) * 8;
        if (seg >= tb_count) etrap = 1;
        else begin
            case (acc) 2'd0: perm = w1[30]; 2'd1: perm = w1[29]; 2'd2: perm = w1[28]; default: perm = 0; endcase
            if (!w1[31])                    etrap = 2;
            else if (!perm)                 etrap = 3;
            else if (32'(off) >= {8'h0, w1[23:0]}) etrap = 4;
            else epa = d_base[seg] + 32'(off);
        end
        @(negedge clk);
        rd_q.delete();
        req_valid = 1; req_seg = SEG_W'(seg); req_off = off; req_acc = acc;
        while (!req_ready) @(negedge clk);
        @(posedge clk); busy = 1;
        @(negedge clk); req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        repeat (hold) @(negedge clk);
        chk(rsp_valid == 1, {tag, " R10 held valid"}, 32'(rsp_valid), 1);
        chk(rsp_trap == 3'(etrap), {tag, " trap"}, 32'(rsp_trap), 32'(etrap));
        chk(rsp_paddr == epa, {tag, " paddr"}, rsp_paddr, epa);
        if (etrap == 1) chk(rd_q.size() == 0, {tag, " R3 reads"}, rd_q.size(), 0);
        else if (etrap != 0) begin
            chk(rd_q.size() == 1, {tag, " R5 reads"}, rd_q.size(), 1);
            if (rd_q.size() > 0) chk(rd_q[0] == dadr + 4, {tag, " R4 attr addr"}, rd_q[0], dadr + 4);
        end else begin
            chk(rd_q.size() == 2, {tag, " R9 reads"}, rd_q.size(), 2);
            if (rd_q.size() == 2) begin
                chk(rd_q[0] == dadr + 4, {tag, " R4 attr addr"}, rd_q[0], dadr + 4);
                chk(rd_q[1] == dadr, {tag, " R4 base addr"}, rd_q[1], dadr);
            end
        end
        rsp_ready = 1;
        @(posedge clk); busy = 0;
        @(negedge clk); rsp_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin d_base[i] = 32'h0; d_attr[i] = 32'h0; end
        d_base[0] = 32'h0010_0000; d_attr[0] = 32'hF000_0100; // valid rwx len 0x100
        d_base[1] = 32'h0020_0000; d_attr[1] = 32'hC000_0040; // valid r   len 0x40
        d_base[2] = 32'h0030_0000; d_attr[2] = 32'h0000_0010; // invalid, no perms
        d_base[3] = 32'hFFFF_FFF0; d_attr[3] = 32'h9000_0100; // valid x   len 0x100
        d_base[4] = 32'h0000_3000; d_attr[4] = 32'hF000_0010; // valid rwx len 0x10
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1 req_ready", 32'(req_ready), 1);
        chk(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
        chk(mem_req_valid == 0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
        started = 1;
        cfg(0, 32'h0000_1000);
        cfg(1, 32'd4);
        xlate(0, 20'h20,  2'd0, 0, "R9 seg0 read");
        xlate(0, 20'hFF,  2'd1, 2, "R7 seg0 write at len-1");
        xlate(0, 20'h100, 2'd2, 0, "R7 seg0 exec at len");
        xlate(1, 20'h3F,  2'd0, 3, "R9 seg1 read");
        xlate(1, 20'h10,  2'd1, 0, "R6 seg1 write denied");
        xlate(1, 20'h40,  2'd0, 0, "R7 seg1 read at len");
        xlate(1, 20'h40,  2'd1, 0, "R8 perm before length");
        xlate(2, 20'h50,  2'd0, 1, "R5 R8 invalid first");
        xlate(3, 20'h20,  2'd2, 0, "R9 wrap exec");
        xlate(3, 20'h20,  2'd0, 0, "R6 seg3 read denied");
        xlate(3, 20'h20,  2'd3, 0, "R6 code3 denied");
        xlate(4, 20'h5,   2'd0, 0, "R3 R8 count before desc");
        xlate(15, 20'h0,  2'd0, 2, "R3 max seg");
        cfg(0, 32'h0000_2000);
        cfg(1, 32'd5);
        xlate(4, 20'h5,   2'd0, 0, "R2 moved table seg4");
        xlate(0, 20'h1,   2'd2, 0, "R2 moved table seg0");
        cfg(1, 32'd0);
        xlate(0, 20'h1,   2'd0, 0, "R2 R3 empty table");
        started = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule